// File: doc/BRIEF.md
# Two-Lane Pixel Transaction Framer

This block turns a parallel pixel stream (18 colour bits plus horizontal sync, vertical sync and data-enable strobes) into a 24-bit transaction. The transaction leaves on two serial lanes, one bit per lane on each tick of a fast clock. A tick stands for one half of a serial-clock cycle, so twelve ticks carry one pixel. Each transaction also carries an odd-parity bit and a two-bit rolling sequence number. A receiver can find transaction boundaries from the sequence alone, with no line coding on the payload.

The block samples the pixel inputs on the edge that opens a new transaction and flags that edge one cycle ahead with `pix_take`. While `link_en` is low the lanes stay quiet and the sequence counter returns to zero. The next transaction after `link_en` rises therefore carries sequence value 0. Colour depths below 18 bits enter at the upper end of the colour field, and the block fills the low bits with zero.

Top module: `pix_lane_framer`

## Requirements
- R1: While `rst` is high or `link_en` was low at the previous clock edge, `lane0`, `lane1` and `frame_start` are all 0 after that edge.
- R2: With `link_en` held high, every transaction lasts exactly 12 ticks. `frame_start` is 1 on the first tick of each transaction and 0 on the other 11.
- R3: Lane 1 tick 0 carries the sequence MSB and lane 1 tick 1 carries the sequence LSB. The sequence never travels on lane 0.
- R4: The sequence value rises by one with every transaction and wraps from 3 back to 0.
- R5: The first transaction after `link_en` rises, or after reset, carries sequence value 0.
- R6: Lane 1 tick 3 carries a parity bit. The parity bit, the 18 colour bits and the three strobes together hold an odd number of ones.
- R7: The remaining bits take fixed positions. Lane 1 tick 2 carries DE, and lane 1 ticks 4 to 11 carry colour bits 17 down to 10. Lane 0 ticks 0 and 1 carry HS and VS, and lane 0 ticks 2 to 11 carry colour bits 9 down to 0.
- R8: With `COLOR_W` below 18, the input colour fills colour bits 17 down to 18-`COLOR_W`, and the lower colour bits are sent as 0.
- R9: `pix_take` is high exactly when the next clock edge samples the pixel inputs. That happens on the first enabled cycle and every 12 cycles after it. Pixel input changes at any other edge have no effect on the lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one tick per lane bit |
| rst | input | 1 | Synchronous active-high reset |
| link_en | input | 1 | Link running; low holds the lanes quiet and clears the sequence |
| pix_color | input | COLOR_W | Pixel colour, MSB-aligned into the 18-bit field |
| pix_hs | input | 1 | Horizontal sync strobe |
| pix_vs | input | 1 | Vertical sync strobe |
| pix_de | input | 1 | Data-enable strobe |
| pix_take | output | 1 | The next edge samples the pixel inputs |
| lane0 | output | 1 | Serial data lane 0 |
| lane1 | output | 1 | Serial data lane 1 (carries the sequence) |
| frame_start | output | 1 | First tick of a transaction |

## Verification
Some properties are checked on every cycle:
- the slot counter never passes the last tick;
- the lanes are quiet after a disabled or reset edge;
- every loaded transaction has odd parity;
- the sequence counter steps by one per load and is 0 whenever the link was off.

Other properties only the bench's scenarios can show:
- exact bit placement per tick;
- that pixel changes between sampling edges leave the lanes untouched;
- MSB alignment of a narrower colour on a second instance;
- the sequence restarting at 0 after the link drops mid-transaction.

A behavioural model compares all of these on every clock.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int PIX_W     = 18;
  localparam int SEQ_W     = 2;
  localparam int NUM_LANES = 2;
  localparam int LANE_BITS = 12;
  localparam int TX_BITS   = NUM_LANES * LANE_BITS;
  localparam int SLOT_W    = $clog2(LANE_BITS);
  // lane 1 payload after sequence, DE and parity; lane 0 payload after HS, VS
  localparam int HI_W      = LANE_BITS - SEQ_W - 2;
  localparam int LO_W      = LANE_BITS - 2;

  typedef logic [LANE_BITS-1:0] lane_word_t;
endpackage

// File: rtl/framer_align.sv
module framer_align
  import framer_pkg::*;
#(
  parameter int COLOR_W = 18
) (
  input  logic [COLOR_W-1:0] color_in,
  output logic [PIX_W-1:0]   color_out
);
  generate
    if (COLOR_W >= PIX_W) begin : g_full
      assign color_out = color_in[COLOR_W-1 -: PIX_W];
    end else begin : g_narrow
      // narrow colour sits at the top, low bits tied to zero (R8)
      assign color_out = {color_in, {(PIX_W-COLOR_W){1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/framer_parity.sv
module framer_parity
  import framer_pkg::*;
(
  input  logic [PIX_W-1:0] color,
  input  logic             hs,
  input  logic             vs,
  input  logic             de,
  output logic             par
);
  // odd parity over colour and strobes (R6)
  assign par = ~(^{color, hs, vs, de});
endmodule

// File: rtl/framer_pack.sv
module framer_pack
  import framer_pkg::*;
(
  input  logic [PIX_W-1:0]                color,
  input  logic                            hs,
  input  logic                            vs,
  input  logic                            de,
  input  logic                            par,
  input  logic [SEQ_W-1:0]                fseq,
  output lane_word_t [NUM_LANES-1:0]      words
);
  // bit LANE_BITS-1 of each word is sent first (R3, R7)
  assign words[1] = {fseq, de, par, color[PIX_W-1 -: HI_W]};
  assign words[0] = {hs, vs, color[LO_W-1:0]};
endmodule

// File: rtl/framer_seq.sv
module framer_seq
  import framer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             adv,
  output logic [SEQ_W-1:0] fseq
);
  always_ff @(posedge clk) begin
    if (rst || !run) fseq <= '0;
    else if (adv)    fseq <= fseq + 1'b1;
  end

  p_seq_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(run && adv)) |-> fseq == $past(fseq) + 1'b1);

  p_seq_restart_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> fseq == '0);
endmodule

// File: rtl/framer_shift.sv
module framer_shift
  import framer_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       run,
  input  lane_word_t [NUM_LANES-1:0] words,
  output logic                       take,
  output logic [NUM_LANES-1:0]       lanes,
  output logic                       sof
);
  localparam int LAST = LANE_BITS - 1;

  logic              act;
  logic [SLOT_W-1:0] slot;

  assign take = run && (!act || slot == SLOT_W'(LAST));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      act  <= 1'b0;
      slot <= '0;
      sof  <= 1'b0;
    end else if (take) begin
      act  <= 1'b1;
      slot <= '0;
      sof  <= 1'b1;
    end else begin
      slot <= slot + 1'b1;
      sof  <= 1'b0;
    end
  end

  genvar ln;
  generate
    for (ln = 0; ln < NUM_LANES; ln++) begin : g_lane
      lane_word_t sh;
      always_ff @(posedge clk) begin
        if (rst || !run) begin
          sh        <= '0;
          lanes[ln] <= 1'b0;
        end else if (take) begin
          lanes[ln] <= words[ln][LAST];
          sh        <= {words[ln][LAST-1:0], 1'b0};
        end else begin
          lanes[ln] <= sh[LAST];
          sh        <= {sh[LAST-1:0], 1'b0};
        end
      end
    end
  endgenerate

  p_slot_bound_r2: assert property (@(posedge clk) disable iff (rst)
    act |-> slot <= SLOT_W'(LAST));

  p_sof_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    sof |=> !sof);

  p_odd_parity_r6: assert property (@(posedge clk) disable iff (rst)
    take |-> (^{words[1][LANE_BITS-SEQ_W-1:0], words[0]}) == 1'b1);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) || !$past(run)) |-> (lanes == '0 && !sof));
endmodule

// File: rtl/pix_lane_framer.sv
module pix_lane_framer
  import framer_pkg::*;
#(
  parameter int COLOR_W = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               link_en,
  input  logic [COLOR_W-1:0] pix_color,
  input  logic               pix_hs,
  input  logic               pix_vs,
  input  logic               pix_de,
  output logic               pix_take,
  output logic               lane0,
  output logic               lane1,
  output logic               frame_start
);
  logic [PIX_W-1:0]           color18;
  logic                       par;
  logic [SEQ_W-1:0]           fseq;
  lane_word_t [NUM_LANES-1:0] words;
  logic [NUM_LANES-1:0]       lanes;
  logic                       take;

  framer_align #(.COLOR_W(COLOR_W)) u_align (
    .color_in (pix_color),
    .color_out(color18)
  );

  framer_parity u_par (
    .color(color18), .hs(pix_hs), .vs(pix_vs), .de(pix_de), .par(par)
  );

  framer_seq u_seq (
    .clk(clk), .rst(rst), .run(link_en), .adv(take), .fseq(fseq)
  );

  framer_pack u_pack (
    .color(color18), .hs(pix_hs), .vs(pix_vs), .de(pix_de),
    .par(par), .fseq(fseq), .words(words)
  );

  framer_shift u_shift (
    .clk(clk), .rst(rst), .run(link_en), .words(words),
    .take(take), .lanes(lanes), .sof(frame_start)
  );

  assign pix_take = take;
  assign lane0    = lanes[0];
  assign lane1    = lanes[1];
endmodule

// File: tb/pix_lane_framer_tb.sv
module pix_lane_framer_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, link_en, hs, vs, de;
  logic [17:0] color;
  logic take_w, l0_w, l1_w, sof_w;
  logic take_n, l0_n, l1_n, sof_n;

  pix_lane_framer #(.COLOR_W(18)) u_dut (
    .clk(clk), .rst(rst), .link_en(link_en), .pix_color(color),
    .pix_hs(hs), .pix_vs(vs), .pix_de(de), .pix_take(take_w),
    .lane0(l0_w), .lane1(l1_w), .frame_start(sof_w)
  );

  pix_lane_framer #(.COLOR_W(16)) u_dut_narrow (
    .clk(clk), .rst(rst), .link_en(link_en), .pix_color(color[17:2]),
    .pix_hs(hs), .pix_vs(vs), .pix_de(de), .pix_take(take_n),
    .lane0(l0_n), .lane1(l1_n), .frame_start(sof_n)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural model state
  int mact = 0, mslot = 0, mf = 0;
  bit first_tx = 0;
  bit w0[12], w1[12], n0[12], n1[12];

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic build(input logic [17:0] d, input bit h, input bit v,
                       input bit e, input int f, input bit narrow);
    bit a[12], b[12];
    logic [17:0] dd;
    int ones;
    dd = narrow ? {d[17:2], 2'b00} : d;
    ones = h + v + e;
    for (int i = 0; i < 18; i++) ones += dd[i];
    b[0] = f[1]; b[1] = f[0]; b[2] = e; b[3] = (ones % 2 == 0);
    for (int i = 0; i < 8; i++)  b[4+i] = dd[17-i];
    a[0] = h; a[1] = v;
    for (int i = 0; i < 10; i++) a[2+i] = dd[9-i];
    for (int i = 0; i < 12; i++) begin
      if (narrow) begin n0[i] = a[i]; n1[i] = b[i]; end
      else        begin w0[i] = a[i]; w1[i] = b[i]; end
    end
  endtask

  function automatic string l1tag(int s);
    if (s == 0 || s == 1) return first_tx ? "R5" : (s == 0 ? "R3" : "R4");
    if (s == 3) return "R6";
    return "R7";
  endfunction

  task automatic compare();
    if (mact == 0) begin
      chk("R1 lane0", l0_w, 0);
      chk("R1 lane1", l1_w, 0);
      chk("R1 frame_start", sof_w, 0);
      chk("R1 narrow lane0", l0_n, 0);
    end else begin
      chk("R2 frame_start", sof_w, mslot == 0);
      chk(mslot < 2 ? "R7 lane0 strobes" : "R7 lane0", l0_w, w0[mslot]);
      chk(l1tag(mslot), l1_w, w1[mslot]);
      chk("R8 narrow lane0", l0_n, n0[mslot]);
      chk("R8 narrow lane1", l1_n, n1[mslot]);
    end
  endtask

  // one negedge-to-negedge cycle
  task automatic step(bit r, bit en, logic [17:0] d, bit h, bit v, bit e);
    bit exp_take;
    compare();
    rst = r; link_en = en; color = d; hs = h; vs = v; de = e;
    #1;
    exp_take = !r && en && (mact == 0 || mslot == 11);
    if (!r) begin
      chk("R9 pix_take", take_w, exp_take);
      chk("R9 narrow pix_take", take_n, exp_take);
    end
    if (r || !en) begin
      mact = 0; mslot = 0; mf = 0; first_tx = 0;
    end else if (mact == 0 || mslot == 11) begin
      first_tx = (mact == 0);
      build(d, h, v, e, mf, 0);
      build(d, h, v, e, mf, 1);
      mact = 1; mslot = 0; mf = (mf + 1) % 4;
    end else begin
      mslot++;
      if (mslot == 11) first_tx = first_tx;
    end
    @(negedge clk);
  endtask

  task automatic run_px(int n, bit en);
    for (int i = 0; i < n; i++) begin
      logic [17:0] d;
      d = 18'($urandom);
      if (i % 37 == 5)  d = '0;
      if (i % 41 == 7)  d = '1;
      step(0, en, d, 1'($urandom), 1'($urandom), 1'($urandom));
    end
  endtask

  initial begin
    rst = 1; link_en = 0; color = '0; hs = 0; vs = 0; de = 0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(1, 0, '0, 0, 0, 0);
    run_px(5, 0);               // R1 idle
    run_px(400, 1);             // R2-R9, random pixels each tick
    run_px(7, 0);               // drop mid-transaction
    run_px(150, 1);             // R5 restart
    for (int i = 0; i < 2; i++) step(1, 1, 18'h2AAAA, 1, 0, 1);
    run_px(200, 1);             // R5 after reset
    for (int i = 0; i < 30; i++) step(0, 1, '0, 0, 0, 0);
    for (int i = 0; i < 30; i++) step(0, 1, '1, 1, 1, 1);
    compare();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got 0 expected 1 (run completed)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule